// File: doc/BRIEF.md
# Pipelined Data Memory Slave Controller

This block sits on the memory side of a processor's pipelined data port and serves it from a small internal word-addressed RAM. The processor presents an address-phase request one cycle ahead of each transfer: byte address, a 2-bit size code, direction, a lock flag, a sequential hint and a 5-bit mode. In the following cycle, the data cycle, the controller returns steered read data or stores steered write data. In that same cycle it raises an abort for any access it refuses. Refused cases are the reserved size code, misaligned halfword or word addresses, and user-mode accesses to a protected byte window. A refused access leaves the RAM untouched.

A second bus master shares the RAM through a valid/ready word port. When both sides request in the same cycle, the arbiter alternates between them. A locked processor sequence keeps the second master out until the lock flag has been low for a cycle. Back-pressure rules are as follows. A processor request is taken at a clock edge where `p_req` is high and `p_wait` is low; while `p_wait` is high the processor must hold its request unchanged. A master request is taken at an edge where `m_valid` and `m_ready` are both high; the master must hold `m_valid` and its fields until then. Master read data carries no back-pressure: it is shown for exactly one cycle with `m_rvalid`.

Top module: `dmem_slave_ctrl`

## Requirements
- R1: After reset, `p_abort`, `p_wait`, `m_ready` and `m_rvalid` are low while no request is pending.
- R2: A processor access taken at a clock edge is performed in the next cycle (the data cycle); `p_abort` and `p_rdata` are valid during that cycle. A word read returns the whole stored word.
- R3: Size code 00 is a byte, 01 a halfword and 10 a word (little-endian lanes). A byte read returns lane `addr[1:0]` zero-extended in bits 7:0. A halfword read returns lanes 2*`addr[1]` and 2*`addr[1]`+1 zero-extended in bits 15:0.
- R4: A byte write stores `p_wdata[7:0]` into lane `addr[1:0]`, and a halfword write stores `p_wdata[15:0]` into the half chosen by `addr[1]`. A word write stores all of `p_wdata`; bytes outside the selected lanes keep their value.
- R5: Size code 11 aborts in the data cycle and changes no memory.
- R6: A halfword access with `addr[0]`=1, or a word access with `addr[1:0]`≠0, aborts and changes no memory.
- R7: An access with mode 5'b10000 (user) to a byte address in PROT_LO..PROT_HI aborts and changes no memory; any other mode value is privileged and allowed there.
- R8: Write data is stored only if `p_wen` is high in the data cycle; a write whose data cycle has `p_wen` low leaves memory unchanged.
- R9: When a taken access had `p_seq` high, the next taken processor access uses the previous word index plus one, whatever its address bits 5:2 say; lane choice and abort checks still use its own address.
- R10: A lone master request gets `m_ready` in the same cycle. A master write is stored at that edge. A master read returns the word at `m_addr` on `m_rdata` with `m_rvalid` high for one cycle after the edge.
- R11: When both sides request in one cycle without a lock, the side that lost the previous contest wins. The processor, when it loses, sees `p_wait` high.
- R12: If `p_lock` was high in the previous cycle, `m_ready` stays low, and a processor request is never made to wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| p_req | input | 1 | Processor address-phase request |
| p_addr | input | AW | Processor byte address |
| p_size | input | 2 | Access size code |
| p_wr | input | 1 | Access is a write |
| p_lock | input | 1 | Locked sequence in progress |
| p_seq | input | 1 | Next access follows sequentially |
| p_mode | input | 5 | Access mode; 5'b10000 is user |
| p_wait | output | 1 | Processor request not taken this cycle |
| p_wen | input | 1 | Write data valid in the data cycle |
| p_wdata | input | 32 | Processor write data |
| p_rdata | output | 32 | Steered read data in the data cycle |
| p_abort | output | 1 | Access refused, in the data cycle |
| m_valid | input | 1 | Second master request valid |
| m_ready | output | 1 | Second master request taken |
| m_wr | input | 1 | Second master write |
| m_addr | input | log2(DEPTH) | Second master word index |
| m_wdata | input | 32 | Second master write word |
| m_rdata | output | 32 | Second master read word |
| m_rvalid | output | 1 | `m_rdata` valid |

## Verification
Byte, halfword and word reads and writes are swept over every low-address combination and all four size codes. This separates lane steering from alignment and reserved-code aborts. Every memory word is then read in both user and privileged modes, which marks where the protected window begins and ends. Directed sequences use a deliberately wrong follow-on address to show that the sequential pointer, not the address, picks the word. Contested and locked cycles show turn alternation and lock blocking at the ports.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  localparam int unsigned LANES  = 4;
  localparam int unsigned WORD_W = 8 * LANES;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } size_e;

  localparam logic [4:0] MODE_USER = 5'b10000;
endpackage

// File: rtl/dmc_lane_decode.sv
module dmc_lane_decode
  import dmc_pkg::*;
(
  input  logic [1:0]       size,
  input  logic [1:0]       alo,
  output logic [LANES-1:0] lanes,
  output logic             bad_shape
);
  always_comb begin
    lanes     = '0;
    bad_shape = 1'b0;
    unique case (size_e'(size))
      SZ_BYTE: lanes[alo] = 1'b1;
      SZ_HALF: begin
        bad_shape = alo[0];
        lanes[{alo[1], 1'b0}] = 1'b1;
        lanes[{alo[1], 1'b1}] = 1'b1;
      end
      SZ_WORD: begin
        bad_shape = |alo;
        lanes     = '1;
      end
      default: bad_shape = 1'b1;
    endcase
  end
endmodule

// File: rtl/dmc_guard.sv
module dmc_guard
  import dmc_pkg::*;
#(
  parameter int unsigned AW      = 12,
  parameter int unsigned PROT_LO = 32'h20,
  parameter int unsigned PROT_HI = 32'h2F
) (
  input  logic [AW-1:0] addr,
  input  logic [4:0]    mode,
  output logic          deny
);
  logic [31:0] a32;
  assign a32  = 32'(addr);
  assign deny = (mode == MODE_USER) && (a32 >= PROT_LO) && (a32 <= PROT_HI);
endmodule

// File: rtl/dmc_arbiter.sv
module dmc_arbiter (
  input  logic clk,
  input  logic rst_n,
  input  logic p_req,
  input  logic p_lock,
  input  logic m_valid,
  output logic p_take,
  output logic m_take,
  output logic p_wait
);
  logic lock_hold;
  logic last_m;

  assign m_take = m_valid && !lock_hold && (!p_req || !last_m);
  assign p_take = p_req && !m_take;
  assign p_wait = p_req && m_take;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_hold <= 1'b0;
      last_m    <= 1'b0;
    end else begin
      lock_hold <= p_lock;
      if (m_take)      last_m <= 1'b1;
      else if (p_take) last_m <= 1'b0;
    end
  end

  AST_LOCK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(p_lock && rst_n) |-> (!m_take && !p_wait)); // R12

  AST_TURN_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(m_take && p_req && rst_n) && p_req) |-> !m_take); // R11
endmodule

// File: rtl/dmc_wordram.sv
module dmc_wordram
  import dmc_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic [LANES-1:0]  p_be,
  input  logic [IDX_W-1:0]  p_idx,
  input  logic [WORD_W-1:0] p_wdata,
  output logic [WORD_W-1:0] p_rdata,
  input  logic              m_we,
  input  logic              m_re,
  input  logic [IDX_W-1:0]  m_idx,
  input  logic [WORD_W-1:0] m_wdata,
  output logic [WORD_W-1:0] m_rdata
);
  logic [WORD_W-1:0] mem [DEPTH];

  assign p_rdata = mem[p_idx];

  always_ff @(posedge clk) begin
    if (m_re) m_rdata <= mem[m_idx];
    if (m_we) mem[m_idx] <= m_wdata;
    for (int b = 0; b < LANES; b++) begin
      if (p_be[b]) mem[p_idx][8*b +: 8] <= p_wdata[8*b +: 8];
    end
  end
endmodule

// File: rtl/dmem_slave_ctrl.sv
module dmem_slave_ctrl
  import dmc_pkg::*;
#(
  parameter int unsigned AW      = 12,
  parameter int unsigned DEPTH   = 16,
  parameter int unsigned PROT_LO = 32'h20,
  parameter int unsigned PROT_HI = 32'h2F
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     p_req,
  input  logic [AW-1:0]            p_addr,
  input  logic [1:0]               p_size,
  input  logic                     p_wr,
  input  logic                     p_lock,
  input  logic                     p_seq,
  input  logic [4:0]               p_mode,
  output logic                     p_wait,
  input  logic                     p_wen,
  input  logic [31:0]              p_wdata,
  output logic [31:0]              p_rdata,
  output logic                     p_abort,
  input  logic                     m_valid,
  output logic                     m_ready,
  input  logic                     m_wr,
  input  logic [$clog2(DEPTH)-1:0] m_addr,
  input  logic [31:0]              m_wdata,
  output logic [31:0]              m_rdata,
  output logic                     m_rvalid
);
  localparam int unsigned IDX_W = $clog2(DEPTH);

  logic             p_take, m_take;
  logic             d_valid, d_wr, chain;
  logic [AW-1:0]    d_addr;
  logic [1:0]       d_size;
  logic [4:0]       d_mode;
  logic [IDX_W-1:0] d_idx;
  logic [LANES-1:0] lanes, we_lanes;
  logic             bad_shape, deny, bad;
  logic [31:0]      wword, rword;

  dmc_arbiter u_arb (
    .clk(clk), .rst_n(rst_n), .p_req(p_req), .p_lock(p_lock),
    .m_valid(m_valid), .p_take(p_take), .m_take(m_take), .p_wait(p_wait)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      d_valid  <= 1'b0;
      d_wr     <= 1'b0;
      d_addr   <= '0;
      d_size   <= '0;
      d_mode   <= '0;
      d_idx    <= '0;
      chain    <= 1'b0;
      m_rvalid <= 1'b0;
    end else begin
      d_valid  <= p_take;
      m_rvalid <= m_take && !m_wr;
      if (p_take) begin
        d_wr   <= p_wr;
        d_addr <= p_addr;
        d_size <= p_size;
        d_mode <= p_mode;
        d_idx  <= chain ? d_idx + 1'b1 : p_addr[IDX_W+1:2];
        chain  <= p_seq;
      end
    end
  end

  dmc_lane_decode u_dec (
    .size(d_size), .alo(d_addr[1:0]), .lanes(lanes), .bad_shape(bad_shape)
  );

  dmc_guard #(.AW(AW), .PROT_LO(PROT_LO), .PROT_HI(PROT_HI)) u_guard (
    .addr(d_addr), .mode(d_mode), .deny(deny)
  );

  assign bad      = bad_shape || deny;
  assign p_abort  = d_valid && bad;
  assign we_lanes = (d_valid && d_wr && p_wen && !bad) ? lanes : '0;
  assign m_ready  = m_take;

  always_comb begin
    unique case (size_e'(d_size))
      SZ_BYTE: wword = {4{p_wdata[7:0]}};
      SZ_HALF: wword = {2{p_wdata[15:0]}};
      default: wword = p_wdata;
    endcase
  end

  dmc_wordram #(.DEPTH(DEPTH)) u_ram (
    .clk(clk), .p_be(we_lanes), .p_idx(d_idx), .p_wdata(wword), .p_rdata(rword),
    .m_we(m_take && m_wr), .m_re(m_take && !m_wr), .m_idx(m_addr),
    .m_wdata(m_wdata), .m_rdata(m_rdata)
  );

  always_comb begin
    p_rdata = '0;
    if (d_valid) begin
      unique case (size_e'(d_size))
        SZ_BYTE: p_rdata = {24'b0, 8'(rword >> {d_addr[1:0], 3'b000})};
        SZ_HALF: p_rdata = {16'b0, 16'(rword >> {d_addr[1], 4'b0000})};
        default: p_rdata = rword;
      endcase
    end
  end

  AST_RSVD_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (d_valid && d_size == 2'b11) |-> p_abort); // R5

  AST_ALIGN_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (d_valid && d_size == 2'b10 && d_addr[1:0] != 2'b00) |-> p_abort); // R6

  AST_USER_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (d_valid && d_mode == MODE_USER && 32'(d_addr) >= PROT_LO && 32'(d_addr) <= PROT_HI)
      |-> p_abort); // R7

  AST_ABORT_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    p_abort |-> (we_lanes == '0)); // R5

  AST_STORE_NEEDS_WEN: assert property (@(posedge clk) disable iff (!rst_n)
    (we_lanes != '0) |-> (p_wen && d_wr)); // R8

  AST_ABORT_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    p_abort |-> $past(p_take)); // R2
endmodule

// File: tb/sim_dmem_slave_ctrl.sv
module sim_dmem_slave_ctrl;
  localparam logic [4:0] USR = 5'b10000;
  localparam logic [4:0] SUP = 5'b10011;
  localparam int unsigned PLO = 32'h20, PHI = 32'h2F;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        p_req = 0, p_wr = 0, p_lock = 0, p_seq = 0, p_wen = 0;
  logic [11:0] p_addr = '0;
  logic [1:0]  p_size = '0;
  logic [4:0]  p_mode = SUP;
  logic [31:0] p_wdata = '0, p_rdata, m_wdata = '0, m_rdata;
  logic        p_wait, p_abort, m_valid = 0, m_ready, m_wr = 0, m_rvalid;
  logic [3:0]  m_addr = '0;
  logic [31:0] shadow [16];
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  dmem_slave_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .p_req(p_req), .p_addr(p_addr), .p_size(p_size),
    .p_wr(p_wr), .p_lock(p_lock), .p_seq(p_seq), .p_mode(p_mode), .p_wait(p_wait),
    .p_wen(p_wen), .p_wdata(p_wdata), .p_rdata(p_rdata), .p_abort(p_abort),
    .m_valid(m_valid), .m_ready(m_ready), .m_wr(m_wr), .m_addr(m_addr),
    .m_wdata(m_wdata), .m_rdata(m_rdata), .m_rvalid(m_rvalid)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic exp_bad(input logic [11:0] a, input logic [1:0] sz, input logic [4:0] md);
    return (sz == 2'b11) || (sz == 2'b01 && a[0]) || (sz == 2'b10 && a[1:0] != 2'b00) ||
           (md == USR && 32'(a) >= PLO && 32'(a) <= PHI);
  endfunction

  function automatic logic [31:0] exp_read(input logic [31:0] w, input logic [11:0] a, input logic [1:0] sz);
    case (sz)
      2'b00:   return {24'b0, w[8*a[1:0] +: 8]};
      2'b01:   return {16'b0, w[16*a[1] +: 16]};
      default: return w;
    endcase
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [11:0] a,
                                        input logic [1:0] sz, input logic [31:0] wd);
    logic [31:0] r = old;
    case (sz)
      2'b00:   r[8*a[1:0] +: 8] = wd[7:0];
      2'b01:   r[16*a[1] +: 16] = wd[15:0];
      2'b10:   r = wd;
      default: ;
    endcase
    return r;
  endfunction

  // One processor access; idx_ovr >= 0 names the word the sequential pointer must pick.
  task automatic cpu_op(input string tag, input logic [11:0] a, input logic [1:0] sz,
                        input logic wr, input logic [31:0] wd, input logic [4:0] md,
                        input logic sq, input logic wen, input int idx_ovr);
    int idx;
    logic bad;
    idx = (idx_ovr >= 0) ? idx_ovr : int'(a[5:2]);
    bad = exp_bad(a, sz, md);
    @(negedge clk);
    p_wen = 0; p_req = 1; p_addr = a; p_size = sz; p_wr = wr; p_mode = md; p_seq = sq;
    @(negedge clk);
    p_req = 0; p_seq = 0; p_wen = wr & wen; p_wdata = wd;
    #1;
    chk({tag, " abort"}, 32'(p_abort), 32'(bad));
    if (!wr && !bad) chk({tag, " rdata"}, p_rdata, exp_read(shadow[idx], a, sz));
    if (wr && wen && !bad) shadow[idx] = merge(shadow[idx], a, sz, wd);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 p_abort", 32'(p_abort), 0);
    chk("R1 p_wait", 32'(p_wait), 0);
    chk("R1 m_ready", 32'(m_ready), 0);
    chk("R1 m_rvalid", 32'(m_rvalid), 0);
    rst_n = 1;

    // R2: fill every word, then read each back whole
    for (int w = 0; w < 16; w++)
      cpu_op("R2 fill", 12'(w*4), 2'b10, 1, 32'hA5C3_0000 ^ (32'(w) * 32'h0101_0111), SUP, 0, 1, -1);
    for (int w = 0; w < 16; w++)
      cpu_op("R2 word read", 12'(w*4), 2'b10, 0, 0, SUP, 0, 1, -1);

    // R3 steering, R5 reserved code, R6 alignment: every low address and size
    for (int a = 0; a < 16; a++)
      for (int s = 0; s < 4; s++)
        cpu_op(s == 3 ? "R5 read" : (exp_bad(12'(a), 2'(s), SUP) ? "R6 read" : "R3 read"),
               12'(a), 2'(s), 0, 0, SUP, 0, 1, -1);

    // R4 write steering; each write followed by a whole-word read
    for (int a = 0; a < 16; a++)
      for (int s = 0; s < 4; s++) begin
        cpu_op(s == 3 ? "R5 write" : (exp_bad(12'(a), 2'(s), SUP) ? "R6 write" : "R4 write"),
               12'(a), 2'(s), 1,
               {8'(a*4+s+64), 8'(~(a*4+s)), 8'(a*3+s), 8'(a+s*16+1)}, SUP, 0, 1, -1);
        cpu_op("R4 readback", 12'((a/4)*4), 2'b10, 0, 0, SUP, 0, 1, -1);
      end

    // R7 protected window in both modes
    for (int w = 0; w < 16; w++) begin
      cpu_op("R7 user", 12'(w*4), 2'b10, 0, 0, USR, 0, 1, -1);
      cpu_op("R7 priv", 12'(w*4), 2'b10, 0, 0, SUP, 0, 1, -1);
    end
    cpu_op("R7 user write", 12'h24, 2'b10, 1, 32'hDEAD_BEEF, USR, 0, 1, -1);
    cpu_op("R7 untouched", 12'h24, 2'b10, 0, 0, SUP, 0, 1, -1);
    cpu_op("R7 priv write", 12'h2C, 2'b00, 1, 32'h0000_005A, SUP, 0, 1, -1);
    cpu_op("R7 priv readback", 12'h2C, 2'b10, 0, 0, SUP, 0, 1, -1);

    // R8 write without data strobe
    cpu_op("R8 no wen", 12'h14, 2'b10, 1, 32'h1234_5678, SUP, 0, 0, -1);
    cpu_op("R8 untouched", 12'h14, 2'b10, 0, 0, SUP, 0, 1, -1);

    // R9 sequential pointer overrides the follow-on address
    cpu_op("R9 first", 12'h0C, 2'b10, 0, 0, SUP, 1, 1, -1);
    cpu_op("R9 follow", 12'h30, 2'b10, 0, 0, SUP, 0, 1, 4);
    cpu_op("R9 chain ends", 12'h00, 2'b10, 0, 0, SUP, 0, 1, -1);

    // R10 lone master write then read
    @(negedge clk);
    p_wen = 0; m_valid = 1; m_wr = 1; m_addr = 4'd7; m_wdata = 32'h0BAD_F00D;
    #1 chk("R10 write ready", 32'(m_ready), 1);
    shadow[7] = 32'h0BAD_F00D;
    @(negedge clk);
    m_wr = 0;
    #1 chk("R10 read ready", 32'(m_ready), 1);
    @(negedge clk);
    m_valid = 0;
    #1 chk("R10 rvalid", 32'(m_rvalid), 1);
    chk("R10 rdata", m_rdata, shadow[7]);
    @(negedge clk);
    #1 chk("R10 rvalid drops", 32'(m_rvalid), 0);
    cpu_op("R10 cpu sees master write", 12'h1C, 2'b10, 0, 0, SUP, 0, 1, -1);

    // R11 contested cycles alternate; processor won last
    @(negedge clk);
    p_req = 1; p_addr = 12'h00; p_size = 2'b10; p_wr = 0; p_mode = SUP;
    m_valid = 1; m_wr = 0; m_addr = 4'd2;
    #1 chk("R11 master turn", 32'(m_ready), 1);
    chk("R11 cpu waits", 32'(p_wait), 1);
    @(negedge clk);
    #1 chk("R11 cpu turn", 32'(p_wait), 0);
    chk("R11 master held", 32'(m_ready), 0);
    chk("R11 master rdata", m_rdata, shadow[2]);
    @(negedge clk);
    p_req = 0; m_valid = 0;
    #1 chk("R11 cpu data", p_rdata, shadow[0]);

    // R12 lock keeps the master out
    @(negedge clk);
    p_req = 1; p_lock = 1; p_addr = 12'h04;
    @(negedge clk);
    p_req = 0; m_valid = 1; m_addr = 4'd1;
    #1 chk("R12 blocked", 32'(m_ready), 0);
    @(negedge clk);
    p_req = 1;
    #1 chk("R12 cpu no wait", 32'(p_wait), 0);
    chk("R12 still blocked", 32'(m_ready), 0);
    @(negedge clk);
    p_req = 0; p_lock = 0;
    #1 chk("R12 lock tail", 32'(m_ready), 0);
    @(negedge clk);
    #1 chk("R12 released", 32'(m_ready), 1);
    @(negedge clk);
    m_valid = 0;
    repeat (2) @(negedge clk);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule